// File: doc/BRIEF.md
# Double-Column Hit Drain Buffer

This unit sits at the foot of a pair of pixel columns. Every pixel in the pair that holds a hit raises a request line. Each cycle the unit picks one of the raised requests, choosing the highest pixel index. It assembles a 24-bit hit word from that pixel's two time stamps and its index. The word is written into a small local queue, and the same cycle sends a one-cycle clear pulse back to the chosen pixel.

A chip-level readout controller empties the queue. It sees a "not empty" flag and the head word, and pops one word per read strobe. When the queue is full the unit grants nothing, so pending pixels keep their hits until space opens up. Hits are not dropped.

Top module: `colpair_drain`

## Requirements
- R1: After reset the queue is empty: `out_ne` is 0 and no clear pulse is issued until a request is present.
- R2: When several pixels request at once, the pixel with the highest index is granted first.
- R3: At most one bit of `pix_clr` is high in any cycle, and only for a pixel whose request is high. The grant and the write of its word happen in that same cycle.
- R4: A stored word is laid out as bits [23:16] leading stamp, bits [15:8] trailing stamp, bits [7:0] pixel index of the granted pixel.
- R5: The queue holds 16 words. When it holds 16, no pixel is granted, even if a read happens in that cycle, and pending requests stay untouched.
- R6: While `out_ne` is 1 and `out_rd` is 0, the head word and `out_ne` are held. Each cycle with `out_rd` and `out_ne` both 1 removes exactly one word.
- R7: A read strobe while `out_ne` is 0 has no effect: the queue stays empty unless a grant happens in that cycle.
- R8: Words leave in grant order. Under any back-pressure, every granted hit leaves exactly once.
- R9: A word granted into an empty queue shows at `out_word` with `out_ne` = 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pix_req | input | NPIX | Per-pixel hit pending |
| pix_lead | input | NPIX*8 | Leading stamps, pixel i at bits [8i+7:8i] |
| pix_trail | input | NPIX*8 | Trailing stamps, pixel i at bits [8i+7:8i] |
| pix_clr | output | NPIX | One-cycle clear to the granted pixel |
| out_ne | output | 1 | Queue holds at least one word |
| out_rd | input | 1 | Pop strobe from the readout controller |
| out_word | output | 24 | Head word of the queue |

## Verification
The hardest situation to reach is a full queue while further pixels are still requesting. In that state grants must stop cleanly and then resume in priority order as reads free space. The stimulus first floods the column with more hits than the queue holds and withholds reads. It then runs a long phase of random hit arrivals against a sparse read strobe, so the queue sits at its limit repeatedly. A final drain makes sure every injected hit comes out exactly once, in order.

// File: rtl/colpair_pkg.sv
package colpair_pkg;
  localparam int STAMP_W = 8;
  localparam int ADDR_W  = 8;
  localparam int WORD_W  = 2 * STAMP_W + ADDR_W;

  function automatic logic [WORD_W-1:0] pack_hit(
    input logic [STAMP_W-1:0] lead,
    input logic [STAMP_W-1:0] trail,
    input logic [ADDR_W-1:0]  addr);
    return {lead, trail, addr};
  endfunction
endpackage

// File: rtl/colpair_pick.sv
module colpair_pick #(
  parameter int NPIX = 128,
  localparam int IDX_W = $clog2(NPIX)
) (
  input  logic [NPIX-1:0]  req,
  input  logic             en,
  output logic [NPIX-1:0]  gnt,
  output logic [IDX_W-1:0] idx,
  output logic             fire
);
  function automatic logic [IDX_W-1:0] top_index(input logic [NPIX-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NPIX; i++)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign idx  = top_index(req);
  assign fire = en && (|req);
  assign gnt  = fire ? (NPIX'(1) << idx) : '0;
endmodule

// File: rtl/colpair_fifo.sv
module colpair_fifo #(
  parameter int W = 24,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [W-1:0]     wdata,
  input  logic             rd,
  output logic [W-1:0]     rdata,
  output logic             ne,
  output logic             full,
  output logic [CNT_W-1:0] level
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign ne    = (level != '0);
  assign full  = (level == CNT_W'(DEPTH));
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr) wptr <= bump(wptr);
      if (rd) rptr <= bump(rptr);
      level <= level + CNT_W'(wr) - CNT_W'(rd);
    end
  end
endmodule

// File: rtl/colpair_drain.sv
module colpair_drain
  import colpair_pkg::*;
#(
  parameter int NPIX  = 128,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(NPIX),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPIX-1:0]         pix_req,
  input  logic [NPIX*STAMP_W-1:0] pix_lead,
  input  logic [NPIX*STAMP_W-1:0] pix_trail,
  output logic [NPIX-1:0]         pix_clr,
  output logic                    out_ne,
  input  logic                    out_rd,
  output logic [WORD_W-1:0]       out_word
);
  logic             fifo_full;
  logic [CNT_W-1:0] fifo_level;
  logic [IDX_W-1:0] grant_idx;
  logic             grant_fire;
  logic             pop_fire;
  logic [WORD_W-1:0] grant_word;

  colpair_pick #(.NPIX(NPIX)) pick_i (
    .req (pix_req),
    .en  (!fifo_full),
    .gnt (pix_clr),
    .idx (grant_idx),
    .fire(grant_fire)
  );

  assign grant_word = pack_hit(pix_lead[grant_idx*STAMP_W +: STAMP_W],
                               pix_trail[grant_idx*STAMP_W +: STAMP_W],
                               ADDR_W'(grant_idx));
  assign pop_fire = out_rd && out_ne;

  colpair_fifo #(.W(WORD_W), .DEPTH(DEPTH)) fifo_i (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (grant_fire),
    .wdata(grant_word),
    .rd   (pop_fire),
    .rdata(out_word),
    .ne   (out_ne),
    .full (fifo_full),
    .level(fifo_level)
  );
endmodule

// File: rtl/colpair_drain_chk.sv
module colpair_drain_chk #(
  parameter int NPIX = 128,
  parameter int DEPTH = 16,
  parameter int WORD_W = 24,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPIX-1:0]   pix_req,
  input logic [NPIX-1:0]   pix_clr,
  input logic              full,
  input logic [CNT_W-1:0]  level,
  input logic              out_ne,
  input logic              out_rd,
  input logic [WORD_W-1:0] out_word
);
  // R3
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pix_clr));
  // R3
  clr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_clr & ~pix_req) == '0);
  // R2
  clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_clr != '0) |-> ((pix_req & ~(pix_clr | (pix_clr - NPIX'(1)))) == '0));
  // R5
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (pix_clr == '0));
  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ne && !out_rd) |=> (out_ne && $stable(out_word)));
  // R7
  empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ne && out_rd && pix_clr == '0) |=> !out_ne);
  // R8
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pix_clr != '0) && !(out_rd && out_ne)) |=> (level == $past(level) + CNT_W'(1)));
endmodule

bind colpair_drain colpair_drain_chk #(.NPIX(NPIX), .DEPTH(DEPTH), .WORD_W(colpair_pkg::WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_req(pix_req), .pix_clr(pix_clr),
  .full(fifo_full), .level(fifo_level), .out_ne(out_ne), .out_rd(out_rd),
  .out_word(out_word)
);

// File: tb/colpair_drain_tb.sv
module colpair_drain_tb_top;
  localparam int NPIX = 128;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic [NPIX-1:0] pend = '0;
  logic [NPIX*8-1:0] lead_flat, trail_flat;
  logic [7:0] lead_arr [NPIX];
  logic [7:0] trail_arr [NPIX];
  logic [NPIX-1:0] pix_clr;
  logic out_ne, rd_r = 0;
  logic [23:0] out_word;

  int checks = 0, fails = 0, cyc = 0, injected = 0, popped = 0;
  bit done = 0, gnt_valid = 0;
  int gnt_idx = 0;
  logic [7:0] seq = 8'd1;
  logic [23:0] q [$];

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < NPIX; i++) begin
      lead_flat[i*8 +: 8]  = lead_arr[i];
      trail_flat[i*8 +: 8] = trail_arr[i];
    end

  colpair_drain #(.NPIX(NPIX), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_req(pend), .pix_lead(lead_flat),
    .pix_trail(trail_flat), .pix_clr(pix_clr), .out_ne(out_ne),
    .out_rd(rd_r), .out_word(out_word));

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int pend_count();
    int n = 0;
    for (int i = 0; i < NPIX; i++) if (pend[i]) n++;
    return n;
  endfunction

  task automatic step(input logic [NPIX-1:0] hits, input logic rd);
    logic [NPIX-1:0] exp_clr;
    int idx;
    @(negedge clk);
    if (gnt_valid) pend[gnt_idx] = 1'b0;
    gnt_valid = 0;
    for (int i = 0; i < NPIX; i++)
      if (hits[i] && !pend[i]) begin
        pend[i] = 1'b1;
        lead_arr[i] = seq;
        trail_arr[i] = seq ^ 8'(i) ^ 8'h5A;
        seq = seq + 8'd1;
        injected++;
      end
    rd_r = rd;
    #1;
    exp_clr = '0;
    idx = -1;
    if (q.size() < DEPTH)
      for (int i = 0; i < NPIX; i++) if (pend[i]) idx = i;
    if (idx >= 0) exp_clr[idx] = 1'b1;
    check(pix_clr == exp_clr, "R2 R3 R5 grant", pix_clr, exp_clr);
    check(out_ne == (q.size() > 0), "R6 R9 not-empty", out_ne, q.size() > 0);
    if (q.size() > 0) check(out_word == q[0], "R8 head order", out_word, q[0]);
    if (rd && q.size() > 0) begin
      void'(q.pop_front());
      popped++;
    end
    if (idx >= 0) begin
      q.push_back({lead_arr[idx], trail_arr[idx], 8'(idx)});
      gnt_valid = 1;
      gnt_idx = idx;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NPIX-1:0] h;
    for (int i = 0; i < NPIX; i++) begin lead_arr[i] = 0; trail_arr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check(out_ne == 0, "R1 empty after reset", out_ne, 0);
    check(pix_clr == '0, "R1 no clear", pix_clr, 0);

    // R9 and R4: single hit into empty queue
    h = '0; h[42] = 1;
    step(h, 0);
    check(out_ne == 0, "R9 same cycle not yet visible", out_ne, 0);
    step('0, 0);
    check(out_ne == 1, "R9 visible next cycle", out_ne, 1);
    check(out_word[7:0] == 8'd42, "R4 address field", out_word[7:0], 42);
    check(out_word[23:16] == lead_arr[42], "R4 leading field", out_word[23:16], lead_arr[42]);
    check(out_word[15:8] == trail_arr[42], "R4 trailing field", out_word[15:8], trail_arr[42]);
    step('0, 1);
    step('0, 0);

    // R2 simultaneous requests
    h = '0; h[5] = 1; h[100] = 1; h[127] = 1; h[0] = 1;
    step(h, 0);
    check(pix_clr[127] == 1, "R2 highest first", pix_clr, 128'(1) << 127);
    repeat (4) step('0, 0);
    check(out_word[7:0] == 8'd127, "R2 head is 127", out_word[7:0], 127);
    repeat (5) step('0, 1);

    // R7 read on empty
    repeat (4) step('0, 1);
    check(out_ne == 0, "R7 empty read no effect", out_ne, 0);

    // R5 flood beyond capacity, no reads
    h = '0;
    for (int i = 0; i < 20; i++) h[i * 6] = 1;
    step(h, 0);
    repeat (25) step('0, 0);
    check(pend_count() == 4, "R5 pending hits kept", pend_count(), 4);
    check(pix_clr == '0, "R5 no grant when full", pix_clr, 0);
    step('0, 1);
    check(pix_clr == '0, "R5 no grant on full even with read", pix_clr, 0);

    // R8 random back-pressure
    for (int n = 0; n < 4000; n++) begin
      h = '0;
      if ($urandom % 2 == 0) h[$urandom % NPIX] = 1;
      if ($urandom % 5 == 0) h[$urandom % NPIX] = 1;
      step(h, (n < 2000) ? ($urandom % 4 == 0) : ($urandom % 2 == 0));
    end

    for (int n = 0; n < 600 && (q.size() > 0 || pend != '0 || gnt_valid); n++) step('0, 1);
    repeat (2) step('0, 1);
    check(popped == injected, "R8 no loss or duplicate", popped, injected);
    check(out_ne == 0, "R8 drained", out_ne, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule